// File: doc/BRIEF.md
# Programmable Wait-State Memory Bus Interface

This block is a slave interface that connects a synchronous system bus to an on-chip nonvolatile memory array. The memory array is modelled here as a small synchronous RAM. When the master raises its data strobe, the interface stretches the cycle by a number of wait states. That number comes from a 2-bit field in a control register. Once the wait states have elapsed, the interface performs the read or write and returns a one-clock acknowledge.

Bursts are signalled by holding the strobe and a burst flag high across consecutive beats. Only the first beat of a burst pays the programmed wait states. A margin-read mode input, sampled with the strobe, gives every read beat a fixed length set by a parameter, whatever the wait field holds.

A small configuration port reaches two registers:
- **Control register** (select 0): holds the wait code in bits [1:0] and a lock flag in bit 4. It accepts writes only in supervisor mode and only while the lock flag is 1. Clearing the lock therefore freezes the register until reset.
- **Test register** (select 1): keeps six bits and also accepts writes only in supervisor mode.

Top module: `wsbiu`

## Requirements
- R1: The wait code sets the cycle length, counted from the clock edge that samples the strobe to the edge that raises the acknowledge, inclusive:
  - code 00 gives 1 wait state (3 clocks)
  - code 01 gives 2 wait states (4 clocks)
  - code 10 gives 3 wait states (5 clocks)
  - code 11 gives 0 wait states (2 clocks)
- R2: `ack` is high for exactly one clock per beat and is raised only after the strobe was sampled high.
- R3: In a burst (`strb` and `burst` kept high after an acknowledge), every beat after the first takes 2 clocks, whatever the wait code.
- R4: A read beat started with `margin` high takes `MARGIN_CYC` clocks (8 by default), for any wait code, on first and later burst beats alike.
- R5: The control register resets to wait code 00 with lock = 1. While lock is 0, control writes are ignored, so lock can never return to 1 before reset.
- R6: A control write with `sup` low leaves the control register unchanged.
- R7: The test register resets to 0 and stores only bits [5:0]; bits [15:6] read 0. A test write with `sup` low leaves it unchanged.
- R8: A wait code written while a beat is in progress does not change that beat; it applies from the next beat start.
- R9: A read returns, in `rdata` while `ack` is high, the last data written to the same address.
- R10: After reset `ack` is 0 and `cfg_rdata` reads 0x0010 for the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strb | input | 1 | Data strobe from the master |
| wr | input | 1 | 1 = write beat, 0 = read beat |
| burst | input | 1 | Continue with another beat after an acknowledge |
| margin | input | 1 | Margin-read mode for read beats |
| addr | input | AW | Word address, sampled at beat start |
| wdata | input | DW | Write data, sampled at beat start |
| rdata | output | DW | Read data, valid while ack is high |
| ack | output | 1 | One-clock beat acknowledge |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | 0 = control register, 1 = test register |
| sup | input | 1 | Supervisor mode of the register access |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read value of the selected register |

## Verification
The bench builds the block with its defaults: a 6-bit address, 16-bit data and an 8-clock margin read. This keeps the margin length clearly apart from all four programmed lengths (2 to 5 clocks), so a margin beat that wrongly used the wait code would show at once. The 64-word array lets bursts and single beats use distinct addresses, so a stale or misrouted read is visible. A behavioural register model follows every configuration write, so lock, supervisor and mid-beat updates are checked on every clock.

// File: rtl/wsbiu.sv
module wsbiu #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int MARGIN_CYC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strb,
  input  logic          wr,
  input  logic          burst,
  input  logic          margin,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          ack,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic          sup,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata
);
  localparam int DEPTH = 1 << AW;
  localparam int CW = $clog2(MARGIN_CYC + 4);

  typedef enum logic [1:0] {IDLE, BUSY, REL} st_t;
  st_t st_q;

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q;
  logic [1:0]    wcode_q;
  logic          lock_q;
  logic [5:0]    test_q;
  logic [CW-1:0] first_load, next_load;
  logic          access;

  assign first_load = (margin && !wr) ? CW'(MARGIN_CYC - 2)
                    : (wcode_q == 2'b11) ? '0 : CW'(wcode_q) + CW'(1);
  assign next_load  = (margin && !wr) ? CW'(MARGIN_CYC - 2) : '0;
  assign access     = (st_q == BUSY) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= IDLE;
      cnt_q   <= '0;
      ack     <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else begin
      ack <= 1'b0;
      case (st_q)
        IDLE: if (strb) begin
          st_q    <= BUSY;
          cnt_q   <= first_load;
          addr_q  <= addr;
          wdata_q <= wdata;
          wr_q    <= wr;
        end
        BUSY: if (cnt_q == '0) begin
          ack  <= 1'b1;
          st_q <= REL;
        end else begin
          cnt_q <= cnt_q - CW'(1);
        end
        REL: if (!strb) begin
          st_q <= IDLE;
        end else if (burst) begin
          st_q    <= BUSY;
          cnt_q   <= next_load;
          addr_q  <= addr;
          wdata_q <= wdata;
          wr_q    <= wr;
        end
        default: st_q <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (access) begin
      if (wr_q) mem[addr_q] <= wdata_q;
      else      rdata <= mem[addr_q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcode_q <= 2'b00;
      lock_q  <= 1'b1;
      test_q  <= '0;
    end else if (cfg_we && sup) begin
      if (cfg_sel) test_q <= cfg_wdata[5:0];
      else if (lock_q) begin
        wcode_q <= cfg_wdata[1:0];
        lock_q  <= cfg_wdata[4];
      end
    end
  end

  assign cfg_rdata = cfg_sel ? {10'b0, test_q} : {11'b0, lock_q, 2'b00, wcode_q};
endmodule

module wsbiu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ack,
  input logic        strb,
  input logic        lock_q,
  input logic [1:0]  wcode_q,
  input logic [5:0]  test_q,
  input logic        cfg_we,
  input logic        cfg_sel,
  input logic        sup,
  input logic [15:0] cfg_rdata
);
  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |=> !ack);
  // R2
  ack_strb_chk: assert property (@(posedge clk) disable iff (!rst_n) ack |-> $past(strb));
  // R5
  lock_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n) !lock_q |=> !lock_q);
  // R5
  wait_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n) !lock_q |=> $stable(wcode_q));
  // R6
  ctrl_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && !sup) |=> ($stable(wcode_q) && $stable(lock_q)));
  // R7
  test_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel && !sup) |=> $stable(test_q));
  // R7
  test_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |-> (cfg_rdata[15:6] == 10'b0));
endmodule

bind wsbiu wsbiu_chk chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .strb(strb), .lock_q(lock_q),
  .wcode_q(wcode_q), .test_q(test_q), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .sup(sup), .cfg_rdata(cfg_rdata)
);

// File: tb/wsbiu_test.sv
module wsbiu_test;
  localparam int AW = 6, DW = 16, MC = 8;
  logic clk = 0, rst_n = 0;
  logic strb = 0, wr = 0, burst = 0, margin = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic ack;
  logic cfg_we = 0, cfg_sel = 0, sup = 0;
  logic [15:0] cfg_wdata = '0, cfg_rdata;
  int runs = 0, fails = 0;
  int ref_code = 0, ref_lock = 1, ref_test = 0;
  logic [DW-1:0] shadow [int];

  always #10 clk = ~clk;

  wsbiu #(.AW(AW), .DW(DW), .MARGIN_CYC(MC)) uut (.*);

  function automatic int len_of(input int code);
    return (code == 3) ? 2 : code + 3;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Register model, updated on the same edges as the design (R5 R6 R7)
  always @(posedge clk) begin
    if (!rst_n) begin
      ref_code <= 0; ref_lock <= 1; ref_test <= 0;
    end else if (cfg_we && sup) begin
      if (cfg_sel) ref_test <= int'(cfg_wdata[5:0]);
      else if (ref_lock == 1) begin
        ref_code <= int'(cfg_wdata[1:0]);
        ref_lock <= int'(cfg_wdata[4]);
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (cfg_sel) check("R7 test reg", int'(cfg_rdata), ref_test);
    else         check("R5/R6 ctrl reg", int'(cfg_rdata), ref_code + 16 * ref_lock);
  end

  task automatic cfg_write(input logic sel, input logic s, input logic [15:0] d);
    cfg_we = 1; cfg_sel = sel; sup = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_sel = 0; sup = 0;
  endtask

  task automatic beat(input string req, input logic w, input logic m, input logic b,
                      input int a, input int exp_len, input logic keep);
    int n = 0;
    strb = 1; wr = w; margin = m; burst = b; addr = AW'(a); wdata = DW'(a * 37 + 5);
    while (n < 40) begin
      @(negedge clk);
      n++;
      if (ack) break;
    end
    check(req, n, exp_len);
    if (w) shadow[a] = DW'(a * 37 + 5);
    else check("R9 read data", int'(rdata), shadow.exists(a) ? int'(shadow[a]) : -1);
    if (!keep) begin
      strb = 0; burst = 0; margin = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R10 ack reset", int'(ack), 0);
    check("R10 ctrl reset", int'(cfg_rdata), 16'h0010);
    cfg_sel = 1; #1;
    check("R7 test reset", int'(cfg_rdata), 0);
    cfg_sel = 0;
    @(negedge clk);

    // R1 every wait code, single write then read
    for (int c = 0; c < 4; c++) begin
      cfg_write(0, 1, 16'(16 + c));
      beat("R1 write len", 1, 0, 0, c + 1, len_of(c), 0);
      beat("R1 read len", 0, 0, 0, c + 1, len_of(c), 0);
    end

    // R3 burst write with code 01, then burst read with code 10
    cfg_write(0, 1, 16'h0011);
    beat("R3 burst first", 1, 0, 1, 10, 4, 1);
    beat("R3 burst next", 1, 0, 1, 11, 2, 1);
    beat("R3 burst next", 1, 0, 1, 12, 2, 0);
    cfg_write(0, 1, 16'h0012);
    beat("R3 burst first", 0, 0, 1, 10, 5, 1);
    beat("R3 burst next", 0, 0, 1, 11, 2, 1);
    beat("R3 burst next", 0, 0, 1, 12, 2, 0);

    // R4 margin read ignores wait code, single and burst
    beat("R4 margin", 0, 1, 0, 11, MC, 0);
    cfg_write(0, 1, 16'h0013);
    beat("R4 margin", 0, 1, 1, 10, MC, 1);
    beat("R4 margin burst", 0, 1, 1, 12, MC, 0);

    // R8 mid-beat change: code 00 active, 10 written during the beat
    cfg_write(0, 1, 16'h0010);
    begin
      int n = 0;
      strb = 1; wr = 0; margin = 0; burst = 0; addr = AW'(1);
      @(negedge clk); n++;
      cfg_write(0, 1, 16'h0012); n++;
      while (!ack && n < 40) begin @(negedge clk); n++; end
      check("R8 beat keeps old code", n, 3);
      strb = 0; @(negedge clk);
      beat("R8 next beat new code", 0, 0, 0, 1, 5, 0);
    end

    // R6 user-mode control write ignored
    cfg_write(0, 0, 16'h0013);
    beat("R6 user write ignored", 0, 0, 0, 2, 5, 0);

    // R7 test register width and supervisor rule
    cfg_write(1, 1, 16'hFFFF);
    cfg_sel = 1; #1; check("R7 six bits", int'(cfg_rdata), 63); cfg_sel = 0;
    cfg_write(1, 0, 16'h0000);
    cfg_sel = 1; #1; check("R7 user write ignored", int'(cfg_rdata), 63); cfg_sel = 0;

    // R5 clear lock with code 11, then attempt to reopen
    cfg_write(0, 1, 16'h0003);
    cfg_write(0, 1, 16'h0010);
    #1; check("R5 lock stays clear", int'(cfg_rdata), 3);
    beat("R5 code frozen", 0, 0, 0, 3, 2, 0);
    beat("R9 read after lock", 0, 0, 0, 4, 2, 0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule